// File: doc/BRIEF.md
# Segment Descriptor Lookaside Table

This block keeps a small, fully associative table of segment descriptors, each made of two 64-bit words: an effective-segment word that carries the segment tag and a valid flag, and a virtual-segment word whose top two bits give the segment size. A probe address is matched against every entry at the same time. Each entry is compared at its own granularity, 256 MB or 1 TB, as its size field selects. The lowest matching slot is reported together with its virtual-segment word.

Software-style maintenance runs through a set of single-cycle strobes. A checked write stores a descriptor into a numbered slot and reports a reject when the operands are malformed. Indexed reads return either word of a slot. Invalidate-by-address and invalidate-all drop entries, and any invalidation that actually removes a live entry raises a one-cycle flush pulse for the translation cache downstream. All results are registered and appear one cycle after the request.

When several state-changing strobes arrive in one cycle, invalidate-all wins over invalidate-by-address, which wins over a write. The losers have no effect.

Top module: `slb_array`

## Requirements
- R1: After reset every output is zero and every slot reads back zero in both words.
- R2: The valid flag is bit 27 of the effective-segment word, and the size field is bits 63:62 of the virtual-segment word (00 = 256 MB, 01 = 1 TB). An entry matches a probe address when its effective-segment word equals the address with bits 27:0 cleared and bit 27 set and its size is 00, or when it equals the address with bits 39:0 cleared and bit 27 set and its size is 01.
- R3: When several entries match, the lowest slot number is reported. A lookup returns hit, that slot and its virtual-segment word. A miss returns hit, slot and word all zero.
- R4: Lookup and read results appear on the outputs one cycle after the request. They reflect the table as it stood before any update made in the same cycle.
- R5: The write slot is bits 11:0 of the first operand. A slot value at or above the entry count (32) is rejected with a one-cycle reject pulse, and a rejected write leaves the table unchanged.
- R6: A write whose size field holds 10 or 11 is rejected.
- R7: A write with size 01 is rejected while the 1 TB enable input is low, and accepted while it is high.
- R8: An accepted write stores only bits 63:28 and bit 27 of the first operand as the effective-segment word, and stores the second operand unchanged as the virtual-segment word.
- R9: An indexed read returns the effective-segment word when the select is 0 and the virtual-segment word when it is 1. A slot value at or above 32 raises the error output and returns zero data.
- R10: Invalidate-all clears the valid flag of every slot except slot 0. It pulses flush for one cycle only if some slot other than 0 was valid.
- R11: Invalidate-by-address clears the valid flag of the entry that a lookup of that address would report, and pulses flush. On a miss it changes nothing and raises no flush.
- R12: When strobes coincide, invalidate-all takes precedence over invalidate-by-address, which takes precedence over a write. A write that loses is not stored and raises no reject.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg1t_en | input | 1 | Allows 1 TB descriptors to be written |
| lk_en | input | 1 | Lookup request |
| lk_ea | input | 64 | Lookup effective address |
| lk_hit_o | output | 1 | Registered lookup hit |
| lk_slot_o | output | 5 | Registered slot of the winning entry |
| lk_vsid_o | output | 64 | Registered virtual-segment word of the winner |
| wr_en | input | 1 | Write request |
| wr_rb | input | 64 | Slot number and effective-segment operand |
| wr_rs | input | 64 | Virtual-segment operand |
| wr_reject_o | output | 1 | One-cycle pulse for a rejected write |
| rd_en | input | 1 | Indexed read request |
| rd_sel | input | 1 | 0 reads the effective word, 1 reads the virtual word |
| rd_slot | input | 12 | Slot field for the indexed read |
| rd_data_o | output | 64 | Registered read data |
| rd_err_o | output | 1 | Registered out-of-range read error |
| inv_addr_en | input | 1 | Invalidate-by-address request |
| inv_ea | input | 64 | Address for invalidate-by-address |
| inv_all_en | input | 1 | Invalidate-all request |
| flush_o | output | 1 | One-cycle translation-cache flush request |

## Verification
Directed probes try 256 MB and 1 TB descriptors with addresses that differ only inside and only outside each granularity window. This shows whether the mask width follows the size field. Tables holding duplicate tags at different slots show whether the lowest-slot rule holds, and writing and looking up one tag in the same cycle shows whether lookups use the state from before the update. A long random phase draws tags from a small pool, so that hits, duplicates, 1 TB entries with stray middle bits, malformed writes and coinciding strobes all occur often. Every output is compared on every cycle with a behavioural model.

// File: rtl/slb_pkg.sv
package slb_pkg;
   localparam logic [1:0] SZ_SMALL = 2'b00;
   localparam logic [1:0] SZ_LARGE = 2'b01;

   typedef enum logic {
      RD_TAG_WORD = 1'b0,
      RD_SEG_WORD = 1'b1
   } rd_word_e;
endpackage

// File: rtl/slb_match.sv
module slb_match #(
   parameter int ENTRIES     = 32,
   parameter int WORD_W      = 64,
   parameter int SMALL_SHIFT = 28,
   parameter int LARGE_SHIFT = 40,
   parameter int VALID_BIT   = 27,
   localparam int IDX_W      = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0][WORD_W-1:0] tag_tab,
   input  logic [ENTRIES-1:0][1:0]        size_tab,
   input  logic [WORD_W-1:0]              probe_ea,
   output logic                           hit,
   output logic [IDX_W-1:0]               idx
);
   import slb_pkg::*;

   localparam logic [WORD_W-1:0] SMALL_MASK = {WORD_W{1'b1}} << SMALL_SHIFT;
   localparam logic [WORD_W-1:0] LARGE_MASK = {WORD_W{1'b1}} << LARGE_SHIFT;
   localparam logic [WORD_W-1:0] VFLAG      = {{(WORD_W-1){1'b0}}, 1'b1} << VALID_BIT;

   logic [WORD_W-1:0]  key_small;
   logic [WORD_W-1:0]  key_large;
   logic [ENTRIES-1:0] match_vec;

   assign key_small = (probe_ea & SMALL_MASK) | VFLAG;
   assign key_large = (probe_ea & LARGE_MASK) | VFLAG;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match_vec[g] = ((tag_tab[g] == key_small) && (size_tab[g] == SZ_SMALL)) ||
                            ((tag_tab[g] == key_large) && (size_tab[g] == SZ_LARGE));
   end

   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match_vec[i]) begin
            hit = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/slb_wr_check.sv
module slb_wr_check #(
   parameter int ENTRIES     = 32,
   parameter int WORD_W      = 64,
   parameter int SLOT_W      = 12,
   parameter int SMALL_SHIFT = 28,
   parameter int VALID_BIT   = 27,
   localparam int IDX_W      = $clog2(ENTRIES)
) (
   input  logic [WORD_W-1:0] rb,
   input  logic [WORD_W-1:0] rs,
   input  logic              seg1t_en,
   output logic              bad,
   output logic [IDX_W-1:0]  slot,
   output logic [WORD_W-1:0] tag_keep
);
   import slb_pkg::*;

   localparam logic [WORD_W-1:0] KEEP_MASK = ({WORD_W{1'b1}} << SMALL_SHIFT) |
                                             ({{(WORD_W-1){1'b0}}, 1'b1} << VALID_BIT);

   logic [SLOT_W-1:0] slot_field;
   logic [1:0]        size_fld;
   logic              bad_slot, bad_size, bad_large;

   assign slot_field = rb[SLOT_W-1:0];
   assign size_fld   = rs[WORD_W-1 -: 2];
   assign bad_slot   = (slot_field >> IDX_W) != '0;
   assign bad_size   = (size_fld != SZ_SMALL) && (size_fld != SZ_LARGE);
   assign bad_large  = (size_fld == SZ_LARGE) && !seg1t_en;
   assign bad        = bad_slot || bad_size || bad_large;
   assign slot       = slot_field[IDX_W-1:0];
   assign tag_keep   = rb & KEEP_MASK;
endmodule

// File: rtl/slb_array.sv
module slb_array #(
   parameter int ENTRIES     = 32,
   parameter int WORD_W      = 64,
   parameter int SLOT_W      = 12,
   parameter int SMALL_SHIFT = 28,
   parameter int LARGE_SHIFT = 40,
   parameter int VALID_BIT   = 27,
   localparam int IDX_W      = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seg1t_en,
   input  logic              lk_en,
   input  logic [WORD_W-1:0] lk_ea,
   output logic              lk_hit_o,
   output logic [IDX_W-1:0]  lk_slot_o,
   output logic [WORD_W-1:0] lk_vsid_o,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_rb,
   input  logic [WORD_W-1:0] wr_rs,
   output logic              wr_reject_o,
   input  logic              rd_en,
   input  logic              rd_sel,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic [WORD_W-1:0] rd_data_o,
   output logic              rd_err_o,
   input  logic              inv_addr_en,
   input  logic [WORD_W-1:0] inv_ea,
   input  logic              inv_all_en,
   output logic              flush_o
);
   import slb_pkg::*;

   if ((1 << IDX_W) != ENTRIES || ENTRIES < 2) begin : g_chk_entries
      $error("slb_array: ENTRIES must be a power of two and at least 2");
   end
   if (ENTRIES > (1 << SLOT_W)) begin : g_chk_slot
      $error("slb_array: slot field too narrow for ENTRIES");
   end
   if (VALID_BIT < SLOT_W || VALID_BIT >= SMALL_SHIFT || SMALL_SHIFT >= LARGE_SHIFT ||
       LARGE_SHIFT >= WORD_W - 2) begin : g_chk_fields
      $error("slb_array: field positions overlap");
   end

   localparam int PROBES = 2;

   logic [ENTRIES-1:0][WORD_W-1:0] tag_q;
   logic [ENTRIES-1:0][WORD_W-1:0] seg_q;
   logic [ENTRIES-1:0][1:0]        size_vec;
   logic [ENTRIES-1:0]             valid_vec;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_fields
      assign size_vec[g]  = seg_q[g][WORD_W-1 -: 2];
      assign valid_vec[g] = tag_q[g][VALID_BIT];
   end

   // probe 0 serves lookups, probe 1 serves invalidate-by-address
   logic [PROBES-1:0][WORD_W-1:0] probe_ea;
   logic [PROBES-1:0]             probe_hit;
   logic [PROBES-1:0][IDX_W-1:0]  probe_idx;

   assign probe_ea[0] = lk_ea;
   assign probe_ea[1] = inv_ea;

   for (genvar p = 0; p < PROBES; p++) begin : g_probe
      slb_match #(
         .ENTRIES    (ENTRIES),
         .WORD_W     (WORD_W),
         .SMALL_SHIFT(SMALL_SHIFT),
         .LARGE_SHIFT(LARGE_SHIFT),
         .VALID_BIT  (VALID_BIT)
      ) u_match (
         .tag_tab (tag_q),
         .size_tab(size_vec),
         .probe_ea(probe_ea[p]),
         .hit     (probe_hit[p]),
         .idx     (probe_idx[p])
      );
   end

   logic              wr_bad;
   logic [IDX_W-1:0]  wr_slot;
   logic [WORD_W-1:0] wr_tag;

   slb_wr_check #(
      .ENTRIES    (ENTRIES),
      .WORD_W     (WORD_W),
      .SLOT_W     (SLOT_W),
      .SMALL_SHIFT(SMALL_SHIFT),
      .VALID_BIT  (VALID_BIT)
   ) u_wr_check (
      .rb      (wr_rb),
      .rs      (wr_rs),
      .seg1t_en(seg1t_en),
      .bad     (wr_bad),
      .slot    (wr_slot),
      .tag_keep(wr_tag)
   );

   logic             rd_oob;
   logic [IDX_W-1:0] rd_idx;
   rd_word_e         rd_word;

   assign rd_oob  = (rd_slot >> IDX_W) != '0;
   assign rd_idx  = rd_slot[IDX_W-1:0];
   assign rd_word = rd_word_e'(rd_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_q       <= '0;
         seg_q       <= '0;
         lk_hit_o    <= 1'b0;
         lk_slot_o   <= '0;
         lk_vsid_o   <= '0;
         rd_data_o   <= '0;
         rd_err_o    <= 1'b0;
         wr_reject_o <= 1'b0;
         flush_o     <= 1'b0;
      end else begin
         lk_hit_o  <= lk_en && probe_hit[0];
         lk_slot_o <= (lk_en && probe_hit[0]) ? probe_idx[0] : '0;
         lk_vsid_o <= (lk_en && probe_hit[0]) ? seg_q[probe_idx[0]] : '0;

         rd_err_o  <= rd_en && rd_oob;
         if (rd_en && !rd_oob)
            rd_data_o <= (rd_word == RD_SEG_WORD) ? seg_q[rd_idx] : tag_q[rd_idx];
         else
            rd_data_o <= '0;

         flush_o     <= 1'b0;
         wr_reject_o <= 1'b0;
         if (inv_all_en) begin
            for (int i = 1; i < ENTRIES; i++) tag_q[i][VALID_BIT] <= 1'b0;
            flush_o <= |valid_vec[ENTRIES-1:1];
         end else if (inv_addr_en) begin
            if (probe_hit[1]) begin
               tag_q[probe_idx[1]][VALID_BIT] <= 1'b0;
               flush_o <= 1'b1;
            end
         end else if (wr_en) begin
            if (wr_bad) begin
               wr_reject_o <= 1'b1;
            end else begin
               tag_q[wr_slot] <= wr_tag;
               seg_q[wr_slot] <= wr_rs;
            end
         end
      end
   end

   // R10: only slot 0 may stay valid after invalidate-all, and it is untouched
   a_r10_all_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all_en |=> (valid_vec[ENTRIES-1:1] == '0));
   a_r10_slot0_kept: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all_en |=> (valid_vec[0] == $past(valid_vec[0])));
   // R10/R11: a flush pulse needs an invalidation request in the previous cycle
   a_r11_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> $past(inv_all_en || inv_addr_en));
   // R11: a hit by invalidate-by-address always flushes
   a_r11_hit_flushes: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_addr_en && !inv_all_en && probe_hit[1]) |=> flush_o);
   // R5: reject pulse follows a write request, and a rejected write stores nothing
   a_r5_reject_cause: assert property (@(posedge clk) disable iff (!rst_n)
      wr_reject_o |-> $past(wr_en));
   a_r5_reject_no_store: assert property (@(posedge clk) disable iff (!rst_n)
      wr_reject_o |-> $stable(seg_q));
   // R9: read error only from an out-of-range request
   a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err_o |-> ($past(rd_en) && (rd_data_o == '0)));
   // R4: a hit is reported only one cycle after a lookup request
   a_r4_hit_cause: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit_o |-> $past(lk_en));
endmodule

// File: tb/slb_array_tb_top.sv
module slb_array_tb_top;
   localparam int N = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        seg1t_en = 1'b0;
   logic        lk_en = 1'b0;
   logic [63:0] lk_ea = '0;
   logic        lk_hit_o;
   logic [4:0]  lk_slot_o;
   logic [63:0] lk_vsid_o;
   logic        wr_en = 1'b0;
   logic [63:0] wr_rb = '0;
   logic [63:0] wr_rs = '0;
   logic        wr_reject_o;
   logic        rd_en = 1'b0;
   logic        rd_sel = 1'b0;
   logic [11:0] rd_slot = '0;
   logic [63:0] rd_data_o;
   logic        rd_err_o;
   logic        inv_addr_en = 1'b0;
   logic [63:0] inv_ea = '0;
   logic        inv_all_en = 1'b0;
   logic        flush_o;

   always #2 clk = ~clk;

   slb_array dut_i (
      .clk(clk), .rst_n(rst_n), .seg1t_en(seg1t_en),
      .lk_en(lk_en), .lk_ea(lk_ea), .lk_hit_o(lk_hit_o), .lk_slot_o(lk_slot_o),
      .lk_vsid_o(lk_vsid_o), .wr_en(wr_en), .wr_rb(wr_rb), .wr_rs(wr_rs),
      .wr_reject_o(wr_reject_o), .rd_en(rd_en), .rd_sel(rd_sel), .rd_slot(rd_slot),
      .rd_data_o(rd_data_o), .rd_err_o(rd_err_o), .inv_addr_en(inv_addr_en),
      .inv_ea(inv_ea), .inv_all_en(inv_all_en), .flush_o(flush_o)
   );

   int    n_checks = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   string tag = "R1";

   // behavioural reference
   logic [63:0] m_tag [N];
   logic [63:0] m_seg [N];
   logic        e_hit, e_rej, e_err, e_flush;
   logic [4:0]  e_slot;
   logic [63:0] e_vsid, e_data;

   function automatic int ref_find(input logic [63:0] ea);
      logic [63:0] ks, kl;
      ks = {ea[63:28], 28'h8000000};
      kl = {ea[63:40], 40'h0008000000};
      for (int i = 0; i < N; i++) begin
         if ((m_tag[i] == ks && m_seg[i][63:62] == 2'b00) ||
             (m_tag[i] == kl && m_seg[i][63:62] == 2'b01)) return i;
      end
      return -1;
   endfunction

   task automatic model_step();
      int f, s;
      bit any;
      f = ref_find(lk_ea);
      e_hit  = lk_en && f >= 0;
      e_slot = e_hit ? 5'(f) : 5'd0;
      e_vsid = e_hit ? m_seg[f] : 64'd0;
      e_err  = rd_en && rd_slot >= 12'(N);
      e_data = (rd_en && !e_err) ? (rd_sel ? m_seg[rd_slot[4:0]] : m_tag[rd_slot[4:0]]) : 64'd0;
      e_flush = 1'b0;
      e_rej   = 1'b0;
      if (inv_all_en) begin
         any = 1'b0;
         for (int i = 1; i < N; i++) begin
            if (m_tag[i][27]) any = 1'b1;
            m_tag[i][27] = 1'b0;
         end
         e_flush = any;
      end else if (inv_addr_en) begin
         f = ref_find(inv_ea);
         if (f >= 0) begin
            m_tag[f][27] = 1'b0;
            e_flush = 1'b1;
         end
      end else if (wr_en) begin
         s = int'(wr_rb[11:0]);
         if (s >= N || wr_rs[63] || (wr_rs[63:62] == 2'b01 && !seg1t_en)) e_rej = 1'b1;
         else begin
            m_tag[s] = {wr_rb[63:27], 27'd0};
            m_seg[s] = wr_rs;
         end
      end
   endtask

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      lk_en = 0; wr_en = 0; rd_en = 0; inv_addr_en = 0; inv_all_en = 0;
   endtask

   // applies the current inputs for one clock and compares every output
   task automatic cyc();
      model_step();
      @(posedge clk);
      @(negedge clk);
      chk("lk_hit", 64'(lk_hit_o), 64'(e_hit));
      chk("lk_slot", 64'(lk_slot_o), 64'(e_slot));
      chk("lk_vsid", lk_vsid_o, e_vsid);
      chk("rd_data", rd_data_o, e_data);
      chk("rd_err", 64'(rd_err_o), 64'(e_err));
      chk("wr_reject", 64'(wr_reject_o), 64'(e_rej));
      chk("flush", 64'(flush_o), 64'(e_flush));
      idle_inputs();
   endtask

   function automatic logic [63:0] mk_rb(input logic [35:0] seg, input logic v, input logic [11:0] slot);
      return {seg, v, 15'h5A5A, slot};
   endfunction

   task automatic do_wr(input logic [63:0] rb, input logic [63:0] rs);
      wr_en = 1; wr_rb = rb; wr_rs = rs; cyc();
   endtask
   task automatic do_lk(input logic [63:0] ea);
      lk_en = 1; lk_ea = ea; cyc();
   endtask
   task automatic do_rd(input logic sel, input logic [11:0] slot);
      rd_en = 1; rd_sel = sel; rd_slot = slot; cyc();
   endtask

   initial begin
      repeat (2000000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin m_tag[i] = '0; m_seg[i] = '0; end
      repeat (3) @(negedge clk);
      // R1: outputs zero during and straight after reset
      tag = "R1";
      chk("reset lk_hit", 64'(lk_hit_o), 0);
      chk("reset flush", 64'(flush_o), 0);
      chk("reset rd_data", rd_data_o, 0);
      rst_n = 1'b1;
      do_rd(0, 12'd0);
      do_rd(1, 12'd31);

      // R8: slot bits and junk below bit 27 are dropped
      tag = "R8";
      do_wr(mk_rb(36'hABCDEF001, 1'b1, 12'd3), 64'h0000_1111_2222_3333);
      do_rd(0, 12'd3);
      do_rd(1, 12'd3);

      // R2: 256 MB match and near misses
      tag = "R2";
      do_lk({36'hABCDEF001, 28'h1234567});
      do_lk({36'hABCDEF000, 28'h1234567});
      do_lk({36'hABCDEF003, 28'h0});
      // R7: 1 TB entry rejected while disabled, accepted when enabled
      tag = "R7";
      seg1t_en = 0;
      do_wr(mk_rb(36'h123456000, 1'b1, 12'd5), {2'b01, 62'h77});
      seg1t_en = 1;
      do_wr(mk_rb(36'h123456000, 1'b1, 12'd5), {2'b01, 62'h77});
      tag = "R2";
      do_lk({36'h123456ABC, 28'hFFFFFFF});
      do_lk({36'h123457000, 28'h0});

      // R3: lowest slot wins among duplicates
      tag = "R3";
      do_wr(mk_rb(36'h00000A00F, 1'b1, 12'd7), 64'h7);
      do_wr(mk_rb(36'h00000A00F, 1'b1, 12'd1), 64'h1);
      do_lk({36'h00000A00F, 28'h0});
      do_lk(64'hFFFF_0000_0000_0000);

      // R4: lookup in the same cycle as a write sees the old table
      tag = "R4";
      wr_en = 1; wr_rb = mk_rb(36'hABCDEF001, 1'b1, 12'd2); wr_rs = 64'h22;
      lk_en = 1; lk_ea = {36'hABCDEF001, 28'h0};
      cyc();
      do_lk({36'hABCDEF001, 28'h0});

      // R5: out-of-range slot numbers
      tag = "R5";
      do_wr(mk_rb(36'h1, 1'b1, 12'd32), 64'h5);
      do_wr(mk_rb(36'h1, 1'b1, 12'h800), 64'h5);
      do_wr(mk_rb(36'h1, 1'b1, 12'd31), 64'h5);
      do_rd(0, 12'd31);
      // R6: reserved size encodings
      tag = "R6";
      do_wr(mk_rb(36'h2, 1'b1, 12'd6), {2'b10, 62'h0});
      do_wr(mk_rb(36'h2, 1'b1, 12'd6), {2'b11, 62'h0});
      do_rd(1, 12'd6);

      // R9: indexed reads, in and out of range
      tag = "R9";
      do_rd(1, 12'd5);
      do_rd(0, 12'd40);
      do_rd(1, 12'hFFF);

      // R11: invalidate by address then repeat on a now-missing entry
      tag = "R11";
      inv_addr_en = 1; inv_ea = {36'h00000A00F, 28'h9}; cyc();
      do_lk({36'h00000A00F, 28'h0});
      inv_addr_en = 1; inv_ea = 64'hDEAD_0000_0000_0000; cyc();

      // R10: invalidate-all spares slot 0
      tag = "R10";
      do_wr(mk_rb(36'h000000777, 1'b1, 12'd0), 64'h0A);
      inv_all_en = 1; cyc();
      do_rd(0, 12'd0);
      do_rd(0, 12'd3);
      inv_all_en = 1; cyc();
      do_lk({36'h000000777, 28'h0});

      // R12: coinciding strobes
      tag = "R12";
      inv_all_en = 1; wr_en = 1; wr_rb = mk_rb(36'h3, 1'b1, 12'd9); wr_rs = 64'h9; cyc();
      do_rd(0, 12'd9);
      wr_en = 1; wr_rb = mk_rb(36'h3, 1'b1, 12'd40); wr_rs = 64'h9;
      inv_addr_en = 1; inv_ea = {36'h000000777, 28'h0}; cyc();

      // mixed random traffic, all requirements
      tag = "R3";
      for (int k = 0; k < 4000; k++) begin
         logic [23:0] hi;
         logic [11:0] mid;
         logic [11:0] sl;
         case ($urandom % 3)
            0: hi = 24'h000001;
            1: hi = 24'hABCDEF;
            default: hi = 24'h123456;
         endcase
         case ($urandom % 3)
            0: mid = 12'h000;
            1: mid = 12'h001;
            default: mid = 12'h7FF;
         endcase
         sl = ($urandom % 8 == 0) ? 12'($urandom) : 12'($urandom % N);
         seg1t_en    = ($urandom % 4) != 0;
         lk_en       = $urandom % 2;
         lk_ea       = {hi, mid, 28'($urandom)};
         wr_en       = ($urandom % 3) == 0;
         wr_rb       = {hi, mid, 1'($urandom % 5 != 0), 15'($urandom), sl};
         wr_rs       = {2'($urandom % 5 == 0 ? 2 + $urandom % 2 : $urandom % 2), 30'($urandom), 32'($urandom)};
         rd_en       = $urandom % 2;
         rd_sel      = $urandom % 2;
         rd_slot     = ($urandom % 8 == 0) ? 12'($urandom) : 12'($urandom % N);
         inv_addr_en = ($urandom % 10) == 0;
         inv_ea      = {hi, mid, 28'($urandom)};
         inv_all_en  = ($urandom % 60) == 0;
         cyc();
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule